// File: doc/BRIEF.md
# Receive Frame Status Readout Sequencer

This block gathers the outcome of each frame that an Ethernet-style MAC receiver finishes. It turns that outcome into a four-byte status record, which a host reads one byte at a time from a single register location. Each record holds the 12-bit received byte count, four error flags, and two 8-bit counters. One counter holds the runt frames and the other the collisions seen since the last good frame. Both counters saturate at 255.

The receiver pulses `frm_done` together with the frame's length and error flags. The counters' values at that moment are latched into the new record. The counters are cleared when the frame carries no error. Records wait in a two-entry queue. The host pulses `rd_strb` once per byte, and the byte arrives on `rd_data` one cycle later. After the fourth byte the next queued record moves to the front. A frame that arrives when the queue has no room is dropped. The drop is reported through the overflow flag of the newest record still in the queue.

Top module: `rx_stat_seq`

## Requirements
- R1: After reset, `stat_avail` is 0, `rd_data` is 0 and both event counters are 0.
- R2: A record is read as four bytes in this order: byte 0 is length bits 7..0; byte 1 is length bits 11..8 in bits 3..0 with the flags in bits 7..4 (bit 7 overflow, bit 6 late collision, bit 5 framing error, bit 4 FCS error, taken from `frm_err[3]`..`frm_err[0]`); byte 2 is the runt count; byte 3 is the collision count. The byte appears on `rd_data` in the cycle after the `rd_strb` cycle and holds until the next strobe.
- R3: The runt counter adds one per `runt_pulse` cycle and stays at 255 once it gets there.
- R4: The collision counter adds one per `coll_pulse` cycle and stays at 255 once it gets there.
- R5: A record holds the counter values from before its `frm_done` cycle. An event pulse in that same cycle counts toward the next frame.
- R6: A completion with `frm_err` equal to 0 clears both counters, apart from any pulse in the same cycle, which leaves that counter at 1. A completion with any flag set leaves both counters as they are. This holds whether or not the record was queued.
- R7: The byte pointer moves on each read while status is available. It wraps to byte 0 after byte 3, and at that point the record leaves the queue. `stat_avail` then falls, unless another record is queued.
- R8: The queue holds two records. A completion that arrives while both entries are full, with no fourth-byte read in the same cycle, is dropped and sets the overflow flag (byte 1 bit 7) of the newer queued record. If a fourth-byte read happens in the same cycle, the new record is accepted.
- R9: A read while `stat_avail` is 0 returns 0 and does not move the pointer.
- R10: `stat_avail` rises in the cycle after a `frm_done` cycle that found the queue empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_done | input | 1 | Frame-complete strobe |
| frm_len | input | 12 | Received byte count of the completing frame |
| frm_err | input | 4 | Error flags: [3] overflow, [2] late collision, [1] framing, [0] FCS |
| runt_pulse | input | 1 | One runt frame seen |
| coll_pulse | input | 1 | One collision seen |
| rd_strb | input | 1 | Host read of the status byte |
| rd_data | output | 8 | Status byte returned by the last read |
| stat_avail | output | 1 | At least one status record is queued |

## Verification
Two pairs of functions can coincide in one cycle. In the first, a frame completion meets a runt or collision pulse, so the snapshot and the clear or increment collide. In the second, a completion reaches a full queue in the same cycle as the fourth-byte read that frees an entry. Directed sequences force both pairs: one puts pulses on the `frm_done` cycle, and another keeps the queue full and then completes a frame on the last read. A long random phase makes them occur again. In every cycle a behavioural queue model predicts `rd_data` and `stat_avail`, and any mismatch is reported.

// File: rtl/rx_stat_pkg.sv
package rx_stat_pkg;
    localparam int LEN_W  = 12;
    localparam int FLAG_W = 4;
    localparam int CNT_W  = 8;
    localparam int BYTE_W = 8;
    localparam int OVF_BIT = 3;

    // Record layout: byte k of the readout is bits [8k+7:8k]
    typedef struct packed {
        logic [CNT_W-1:0]  colls;
        logic [CNT_W-1:0]  runts;
        logic [FLAG_W-1:0] flags;
        logic [LEN_W-1:0]  len;
    } stat_rec_t;

    localparam int REC_W     = $bits(stat_rec_t);
    localparam int REC_BYTES = REC_W / BYTE_W;
    localparam int PTR_W     = $clog2(REC_BYTES);
endpackage

// File: rtl/rx_sat_cnt.sv
module rx_sat_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] MAX = {W{1'b1}};

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = inc ? W'(1) : '0;
        end else if (inc && cnt_q != MAX) begin
            cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/rx_stat_fifo.sv
module rx_stat_fifo
    import rx_stat_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  stat_rec_t push_rec,
    input  logic      pop,
    output stat_rec_t head_rec,
    output logic      empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        stat_rec_t [DEPTH-1:0] mem;
        logic [AW-1:0]         head;
        logic [CW-1:0]         cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic          pop_ok, full;
    logic [AW-1:0] wr_idx, tail_idx, head_nxt;

    always_comb begin
        st_d     = st_q;
        full     = (st_q.cnt == CW'(DEPTH));
        pop_ok   = pop && (st_q.cnt != '0);
        wr_idx   = AW'((int'(st_q.head) + int'(st_q.cnt)) % DEPTH);
        tail_idx = AW'((int'(st_q.head) + int'(st_q.cnt) + DEPTH - 1) % DEPTH);
        head_nxt = AW'((int'(st_q.head) + 1) % DEPTH);
        if (pop_ok) begin
            st_d.head = head_nxt;
            st_d.cnt  = st_q.cnt - CW'(1);
        end
        if (push) begin
            if (!full || pop_ok) begin
                st_d.mem[wr_idx] = push_rec;
                st_d.cnt         = st_d.cnt + CW'(1);
            end else begin
                st_d.mem[tail_idx].flags[OVF_BIT] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_rec = st_q.mem[st_q.head];
    assign empty    = (st_q.cnt == '0);
endmodule

// File: rtl/rx_stat_seq.sv
module rx_stat_seq
    import rx_stat_pkg::*;
#(
    parameter int QDEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_done,
    input  logic [LEN_W-1:0]  frm_len,
    input  logic [FLAG_W-1:0] frm_err,
    input  logic              runt_pulse,
    input  logic              coll_pulse,
    input  logic              rd_strb,
    output logic [BYTE_W-1:0] rd_data,
    output logic              stat_avail
);
    localparam int NCNT = 2;

    typedef struct packed {
        logic [PTR_W-1:0]  ptr;
        logic [BYTE_W-1:0] data;
    } rd_st_t;

    rd_st_t           rd_d, rd_q;
    logic             good_done, q_empty, q_pop;
    logic [NCNT-1:0]  ev_pulse;
    logic [CNT_W-1:0] ev_cnt [NCNT];
    logic [CNT_W-1:0] runt_cnt, coll_cnt;
    stat_rec_t        new_rec, head_rec;
    logic [REC_W-1:0] head_bits;

    assign good_done = frm_done && (frm_err == '0);
    assign ev_pulse  = {coll_pulse, runt_pulse};

    for (genvar g = 0; g < NCNT; g++) begin : g_cnt
        rx_sat_cnt #(.W(CNT_W)) cnt_i (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (ev_pulse[g]),
            .clr   (good_done),
            .cnt   (ev_cnt[g])
        );
    end

    assign runt_cnt = ev_cnt[0];
    assign coll_cnt = ev_cnt[1];

    always_comb begin
        new_rec.colls = coll_cnt;
        new_rec.runts = runt_cnt;
        new_rec.flags = frm_err;
        new_rec.len   = frm_len;
    end

    assign q_pop = rd_strb && !q_empty && (rd_q.ptr == PTR_W'(REC_BYTES - 1));

    rx_stat_fifo #(.DEPTH(QDEPTH)) fifo_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (frm_done),
        .push_rec (new_rec),
        .pop      (q_pop),
        .head_rec (head_rec),
        .empty    (q_empty)
    );

    assign head_bits = head_rec;

    always_comb begin
        rd_d = rd_q;
        if (rd_strb) begin
            if (!q_empty) begin
                rd_d.data = head_bits[BYTE_W*rd_q.ptr +: BYTE_W];
                rd_d.ptr  = rd_q.ptr + PTR_W'(1);
            end else begin
                rd_d.data = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data    = rd_q.data;
    assign stat_avail = !q_empty;
endmodule

// File: rtl/rx_stat_seq_chk.sv
module rx_stat_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       frm_done,
    input logic [3:0] frm_err,
    input logic       runt_pulse,
    input logic       coll_pulse,
    input logic       rd_strb,
    input logic [7:0] rd_data,
    input logic       stat_avail,
    input logic [7:0] runt_cnt,
    input logic [7:0] coll_cnt
);
    logic good;
    assign good = frm_done && (frm_err == 4'd0);

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strb |=> $stable(rd_data));

    assert_runt_sat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (runt_cnt == 8'hFF && runt_pulse && !good) |=> runt_cnt == 8'hFF);

    assert_coll_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (coll_cnt == 8'hFF && coll_pulse && !good) |=> coll_cnt == 8'hFF);

    assert_good_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (good && !runt_pulse && !coll_pulse) |=> (runt_cnt == 8'd0 && coll_cnt == 8'd0));

    assert_err_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && !good && !runt_pulse && !coll_pulse) |=> ($stable(runt_cnt) && $stable(coll_cnt)));

    assert_fall_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_avail) |-> $past(rd_strb));

    assert_empty_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_avail && rd_strb) |=> rd_data == 8'd0);

    assert_rise_on_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_avail) |-> $past(frm_done));
endmodule

bind rx_stat_seq rx_stat_seq_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .frm_done   (frm_done),
    .frm_err    (frm_err),
    .runt_pulse (runt_pulse),
    .coll_pulse (coll_pulse),
    .rd_strb    (rd_strb),
    .rd_data    (rd_data),
    .stat_avail (stat_avail),
    .runt_cnt   (runt_cnt),
    .coll_cnt   (coll_cnt)
);

// File: tb/rx_stat_seq_tb_top.sv
module rx_stat_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frm_done = 1'b0;
    logic [11:0] frm_len = '0;
    logic [3:0]  frm_err = '0;
    logic        runt_pulse = 1'b0;
    logic        coll_pulse = 1'b0;
    logic        rd_strb = 1'b0;
    logic [7:0]  rd_data;
    logic        stat_avail;

    always #5 clk = ~clk;

    rx_stat_seq dut_i (
        .clk(clk), .rst_n(rst_n), .frm_done(frm_done), .frm_len(frm_len),
        .frm_err(frm_err), .runt_pulse(runt_pulse), .coll_pulse(coll_pulse),
        .rd_strb(rd_strb), .rd_data(rd_data), .stat_avail(stat_avail)
    );

    // Reference model state (value after the coming edge)
    logic [31:0] m_q[$];
    int          m_runt = 0, m_coll = 0, m_ptr = 0;
    logic [7:0]  m_data = 8'd0;
    int          n_vec = 0, n_bad = 0, cyc = 0;
    string       phase = "R1";

    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        wait (cyc >= 150000);
        n_bad++;
        $display("FAIL watchdog in phase %s: actual cycles=%0d expected below 150000", phase, cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    task automatic check_out();
        n_vec++;
        if (rd_data !== m_data || stat_avail !== (m_q.size() > 0)) begin
            n_bad++;
            $display("FAIL %s cyc %0d: actual data=%02h avail=%0b expected data=%02h avail=%0b",
                     phase, cyc, rd_data, stat_avail, m_data, m_q.size() > 0);
        end
    endtask

    task automatic model_step(bit dn, logic [11:0] ln, logic [3:0] er, bit rp, bit cp, bit rd);
        logic [31:0] rec;
        bit          pop;
        rec = {m_coll[7:0], m_runt[7:0], er, ln};
        pop = 0;
        if (rd) begin
            if (m_q.size() > 0) begin
                m_data = m_q[0][8*m_ptr +: 8];
                pop    = (m_ptr == 3);
                m_ptr  = (m_ptr + 1) % 4;
            end else begin
                m_data = 8'd0;
            end
        end
        if (pop) void'(m_q.pop_front());
        if (dn) begin
            if (m_q.size() < 2) m_q.push_back(rec);
            else m_q[m_q.size()-1][15] = 1'b1;
        end
        if (dn && er == 4'd0) begin
            m_runt = rp ? 1 : 0;
            m_coll = cp ? 1 : 0;
        end else begin
            if (rp && m_runt < 255) m_runt++;
            if (cp && m_coll < 255) m_coll++;
        end
    endtask

    task automatic step(bit dn, logic [11:0] ln, logic [3:0] er, bit rp, bit cp, bit rd);
        @(negedge clk);
        check_out();
        frm_done = dn; frm_len = ln; frm_err = er;
        runt_pulse = rp; coll_pulse = cp; rd_strb = rd;
        model_step(dn, ln, er, rp, cp, rd);
    endtask

    task automatic read4();
        for (int i = 0; i < 4; i++) step(0, 12'h0, 4'h0, 0, 0, 1);
        step(0, 12'h0, 4'h0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        phase = "R1 reset";
        check_out();
        @(negedge clk);
        rst_n = 1'b1;

        phase = "R10 R2 R7 single frame";
        step(1, 12'hA5C, 4'h0, 0, 0, 0);
        step(0, 12'h0, 4'h0, 0, 0, 0);
        read4();
        step(0, 12'h0, 4'h0, 0, 0, 0);

        phase = "R9 empty reads";
        for (int i = 0; i < 3; i++) step(0, 12'h0, 4'h0, 0, 0, 1);
        step(1, 12'h123, 4'h0, 0, 0, 0);
        read4();

        phase = "R5 R6 counts then errored then good";
        for (int i = 0; i < 5; i++) step(0, 12'h0, 4'h0, 1, i < 3, 0);
        step(1, 12'h040, 4'h2, 1, 1, 0);
        read4();
        step(1, 12'h7FF, 4'h0, 1, 0, 0);
        read4();
        step(1, 12'h3C, 4'h0, 0, 0, 0);
        read4();

        phase = "R3 R4 saturation";
        for (int i = 0; i < 300; i++) step(0, 12'h0, 4'h0, 1, 1, 0);
        step(1, 12'h5EE, 4'h1, 1, 1, 0);
        read4();
        step(1, 12'h5EE, 4'h0, 0, 0, 0);
        read4();

        phase = "R8 queue full overflow";
        step(1, 12'h011, 4'h0, 0, 0, 0);
        step(1, 12'h022, 4'h4, 1, 0, 0);
        step(1, 12'h033, 4'h0, 0, 0, 0);
        step(0, 12'h0, 4'h0, 0, 0, 0);
        for (int i = 0; i < 3; i++) step(0, 12'h0, 4'h0, 0, 0, 1);
        phase = "R8 R7 push with final read";
        step(1, 12'h044, 4'h8, 0, 1, 1);
        read4();
        read4();
        step(0, 12'h0, 4'h0, 0, 0, 1);

        phase = "R2 R5 R6 R7 R8 R9 R10 random";
        for (int i = 0; i < 4000; i++)
            step(($urandom % 10) == 0, 12'($urandom), ($urandom % 2) ? 4'($urandom) : 4'h0,
                 ($urandom % 5) == 0, ($urandom % 5) == 0, ($urandom % 5) < 2);
        step(0, 12'h0, 4'h0, 0, 0, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule